// File: doc/BRIEF.md
# Memory-Mapped 64-bit System Time Counter

This block keeps a 64-bit count of elapsed clock cycles for a whole chip and exposes it through a narrow 32-bit register port. The port has an address, a write strobe, write data and a registered read-data output. Software turns counting on and off with a run bit. A second bit lets an external debug-halt input freeze the count while a debugger has the system stopped. A status bit shows whether that freeze is in effect.

While the counter is stopped, software can load a start value one 32-bit half at a time. Writes to the count halves are dropped while the counter runs. The counter therefore never has to settle a load and an increment that arrive together. A plain read/write word holds the base tick frequency in Hz for boot firmware to fill in. A read-only word of zeros marks the end of a one-entry frequency table.

Top module: `sys_timebase`

## Requirements
- R1: After reset, every register reads 0: the control word, the status word, both count halves, the frequency word and the end marker.
- R2: While run (control bit 0) is 1 and no qualified debug halt is active, the count rises by exactly 1 every clock. It wraps from all ones to 0, and the carry passes from the low half into the high half.
- R3: While run is 0, the count holds its value unless a count half is being loaded.
- R4: With freeze-enable (control bit 1) at 1, a high debug-halt input holds the count. With freeze-enable at 0, the debug-halt input has no effect on counting.
- R5: The status word (offset 0x04) reads bit 1 = freeze-enable AND debug-halt input. All its other bits read 0.
- R6: While run is 0, a write to offset 0x08 loads count bits [31:0] and a write to 0x0C loads bits [63:32]. Each load leaves the other half unchanged.
- R7: While run is 1, writes to 0x08 or 0x0C are discarded and counting goes on undisturbed.
- R8: A read returns its data one cycle after the address is presented. It reflects the state in the cycle the address was presented. Offset 0x08 gives count bits [31:0] and 0x0C gives bits [63:32].
- R9: The control word (offset 0x00) reads back run at bit 0 and freeze-enable at bit 1. Bits [31:2] always read 0, and write data in those bits is discarded.
- R10: The frequency word (offset 0x20) is a 32-bit read/write value that resets to 0.
- R11: Offset 0x24 always reads 0. Any offset other than 0x00, 0x04, 0x08, 0x0C, 0x20 and 0x24 reads 0. Writes to these offsets and to the status word change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_halt_i | input | 1 | Debug-halt request from the debug logic |
| bus_addr_i | input | ADDR_W (8) | Byte offset of the register access |
| bus_we_i | input | 1 | Write strobe, one cycle per write |
| bus_wdata_i | input | DATA_W (32) | Write data |
| bus_rdata_o | output | DATA_W (32) | Registered read data for the previous cycle's address |

## Verification
The two functions that can meet in one cycle are a count-half load and a count increment. The bench provokes this by writing 0x08 and 0x0C while the counter runs, and by writing run=1 in the cycle just after a load. A cycle-level model in the bench predicts every read. It takes the load only on the old run bit and the increment only when run is set and no qualified halt is present. A count read is compared against that prediction on every clock, so a load that slips through, or an increment that is lost, shows as a mismatch in the following cycle.

// File: rtl/stb_pkg.sv
package stb_pkg;
  // Register offsets; the read mux and the write decode both use these
  localparam int OFS_CTRL = 'h00;
  localparam int OFS_STAT = 'h04;
  localparam int OFS_CNTL = 'h08;
  localparam int OFS_CNTH = 'h0C;
  localparam int OFS_FREQ = 'h20;
  localparam int OFS_FEND = 'h24;

  // Control and status bit positions
  localparam int BIT_RUN    = 0;
  localparam int BIT_FREEZE = 1;
  localparam int BIT_HELD   = 1;
endpackage

// File: rtl/stb_ctrl_regs.sv
module stb_ctrl_regs
  import stb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              run_o,
  output logic              freeze_o,
  output logic [DATA_W-1:0] freq_o,
  output logic [1:0]        ld_half_o
);
  logic              run_q, run_d;
  logic              frz_q, frz_d;
  logic [DATA_W-1:0] freq_q, freq_d;
  logic              sel_ctrl, sel_freq;

  assign sel_ctrl = we_i && (addr_i == ADDR_W'(OFS_CTRL));
  assign sel_freq = we_i && (addr_i == ADDR_W'(OFS_FREQ));

  // Raw load strobes for the two count halves; the counter applies the run rule
  assign ld_half_o[0] = we_i && (addr_i == ADDR_W'(OFS_CNTL));
  assign ld_half_o[1] = we_i && (addr_i == ADDR_W'(OFS_CNTH));

  always_comb begin
    run_d  = run_q;
    frz_d  = frz_q;
    freq_d = freq_q;
    if (sel_ctrl) begin
      run_d = wdata_i[BIT_RUN];
      frz_d = wdata_i[BIT_FREEZE];
    end
    if (sel_freq) freq_d = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      frz_q  <= 1'b0;
      freq_q <= '0;
    end else begin
      run_q  <= run_d;
      frz_q  <= frz_d;
      freq_q <= freq_d;
    end
  end

  assign run_o    = run_q;
  assign freeze_o = frz_q;
  assign freq_o   = freq_q;

  // R10: a frequency write shows up the next cycle
  p_freq_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sel_freq |=> freq_q == $past(wdata_i));
  // R11: writes elsewhere leave the frequency word alone
  p_freq_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_freq |=> $stable(freq_q));
endmodule

// File: rtl/stb_counter.sv
module stb_counter #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              freeze_i,
  input  logic              dbg_halt_i,
  input  logic [1:0]        ld_half_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              held_o
);
  localparam int NHALF = CNT_W / DATA_W;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             held, step;

  assign held = freeze_i && dbg_halt_i;
  assign step = run_i && !held;

  always_comb begin
    cnt_d = cnt_q;
    if (step) begin
      cnt_d = cnt_q + CNT_W'(1);
    end else if (!run_i) begin
      for (int h = 0; h < NHALF; h++) begin
        if (ld_half_i[h]) cnt_d[h*DATA_W +: DATA_W] = wdata_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o  = cnt_q;
  assign held_o = held;

  // R2: a free cycle advances the count by one, and wraps
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !(freeze_i && dbg_halt_i)) |=> cnt_q == $past(cnt_q) + CNT_W'(1));
  // R3: stopped and not loaded means held
  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && ld_half_i == 2'b00) |=> $stable(cnt_q));
  // R4: a qualified debug halt holds the count
  p_dbg_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze_i && dbg_halt_i && ld_half_i == 2'b00) |=> $stable(cnt_q));
  // R6: a low-half load leaves the high half alone
  p_half_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && ld_half_i == 2'b01) |=>
      cnt_q[CNT_W-1:DATA_W] == $past(cnt_q[CNT_W-1:DATA_W]));
  // R7: loads while running are dropped
  p_load_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && ld_half_i != 2'b00 && !dbg_halt_i) |=>
      cnt_q == $past(cnt_q) + CNT_W'(1));
endmodule

// File: rtl/stb_read_mux.sv
module stb_read_mux
  import stb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              run_i,
  input  logic              freeze_i,
  input  logic              held_i,
  input  logic [DATA_W-1:0] freq_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] rdata_q, rdata_d;

  always_comb begin
    rdata_d = '0;
    if (addr_i == ADDR_W'(OFS_CTRL)) begin
      rdata_d[BIT_RUN]    = run_i;
      rdata_d[BIT_FREEZE] = freeze_i;
    end else if (addr_i == ADDR_W'(OFS_STAT)) begin
      rdata_d[BIT_HELD] = held_i;
    end else if (addr_i == ADDR_W'(OFS_CNTL)) begin
      rdata_d = cnt_i[DATA_W-1:0];
    end else if (addr_i == ADDR_W'(OFS_CNTH)) begin
      rdata_d = cnt_i[CNT_W-1:DATA_W];
    end else if (addr_i == ADDR_W'(OFS_FREQ)) begin
      rdata_d = freq_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign rdata_o = rdata_q;

  // R9: upper control bits read zero
  p_ctrl_rsvd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i == ADDR_W'(OFS_CTRL)) |=> rdata_q[DATA_W-1:2] == '0);
  // R11: table end marker reads zero
  p_fend_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i == ADDR_W'(OFS_FEND)) |=> rdata_q == '0);
  // R5: only bit 1 of status can be set
  p_stat_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i == ADDR_W'(OFS_STAT)) |=> $countones(rdata_q) <= 1 && rdata_q[0] == 1'b0);
endmodule

// File: rtl/sys_timebase.sv
module sys_timebase #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dbg_halt_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_we_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o
);
  localparam int CNT_W = 2 * DATA_W;

  logic              run, freeze, held;
  logic [DATA_W-1:0] freq;
  logic [1:0]        ld_half;
  logic [CNT_W-1:0]  cnt;

  stb_ctrl_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr_i(bus_addr_i), .we_i(bus_we_i),
    .wdata_i(bus_wdata_i), .run_o(run), .freeze_o(freeze), .freq_o(freq),
    .ld_half_o(ld_half)
  );

  stb_counter #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run_i(run), .freeze_i(freeze),
    .dbg_halt_i(dbg_halt_i), .ld_half_i(ld_half), .wdata_i(bus_wdata_i),
    .cnt_o(cnt), .held_o(held)
  );

  stb_read_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_rmux (
    .clk(clk), .rst_n(rst_n), .addr_i(bus_addr_i), .run_i(run),
    .freeze_i(freeze), .held_i(held), .freq_i(freq), .cnt_i(cnt),
    .rdata_o(bus_rdata_o)
  );
endmodule

// File: tb/sys_timebase_tb.sv
`timescale 1ns/1ps
module sys_timebase_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dbg_halt = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int checks = 0;
  int failures = 0;
  string tag = "R1";
  bit done = 1'b0;

  // Reference model state
  longint unsigned m_cnt = 0;
  bit              m_run = 0, m_frz = 0;
  logic [31:0]     m_freq = '0;
  logic [31:0]     exp_rd = '0;

  always #2 clk = ~clk;

  sys_timebase u_dut (
    .clk(clk), .rst_n(rst_n), .dbg_halt_i(dbg_halt), .bus_addr_i(addr),
    .bus_we_i(we), .bus_wdata_i(wdata), .bus_rdata_o(rdata)
  );

  function automatic logic [31:0] model_read(input logic [7:0] a);
    case (a)
      8'h00: return {30'b0, m_frz, m_run};
      8'h04: return {30'b0, (m_frz && dbg_halt), 1'b0};
      8'h08: return m_cnt[31:0];
      8'h0C: return m_cnt[63:32];
      8'h20: return m_freq;
      default: return '0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_run = 0; m_frz = 0; m_freq = '0; exp_rd = '0;
    end else begin
      exp_rd = model_read(addr);
      if (m_run && !(m_frz && dbg_halt)) m_cnt = m_cnt + 1;
      else if (!m_run && we && addr == 8'h08) m_cnt[31:0] = wdata;
      else if (!m_run && we && addr == 8'h0C) m_cnt[63:32] = wdata;
      if (we && addr == 8'h00) begin m_run = wdata[0]; m_frz = wdata[1]; end
      if (we && addr == 8'h20) m_freq = wdata;
    end
  end

  // Compare away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (rdata !== exp_rd) begin
        failures++;
        $display("FAIL %s addr=%h actual=%h expected=%h", tag, addr, rdata, exp_rd);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input int n);
    addr = a;
    cyc(n);
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    // R1: reset values of every register
    tag = "R1";
    rd(8'h00, 1); rd(8'h04, 1); rd(8'h08, 1); rd(8'h0C, 1);
    rd(8'h20, 1); rd(8'h24, 2);
    // R10: frequency word round trip
    tag = "R10";
    wr(8'h20, 32'h0BEB_C200); rd(8'h20, 2);
    // R9: only bits 1:0 of control are kept
    tag = "R9";
    wr(8'h00, 32'hFFFF_FF00); rd(8'h00, 2);
    wr(8'h00, 32'hA5A5_A5FE); rd(8'h00, 2);
    wr(8'h00, 32'h0000_0000); rd(8'h00, 2);
    // R6: half loads while stopped, each leaving the other half
    tag = "R6";
    wr(8'h0C, 32'hFFFF_FFFF); rd(8'h0C, 2);
    wr(8'h08, 32'h0000_1234); rd(8'h0C, 2); rd(8'h08, 2);
    wr(8'h08, 32'hFFFF_FFFC); rd(8'h08, 2);
    // R2: counting, low-half wrap and full 64-bit wrap; R8 latency on every read
    tag = "R2";
    wr(8'h00, 32'h1); rd(8'h08, 6); rd(8'h0C, 3);
    tag = "R8";
    rd(8'h08, 1); rd(8'h0C, 1); rd(8'h08, 1);
    // R7: loads while running are dropped, including a load followed at once by run=1
    tag = "R7";
    wr(8'h08, 32'hDEAD_0000); rd(8'h08, 3);
    wr(8'h0C, 32'h7777_7777); rd(8'h0C, 2);
    wr(8'h00, 32'h0); wr(8'h08, 32'hFFFF_FFF0); wr(8'h00, 32'h1); rd(8'h08, 4);
    // R4: halt ignored with freeze off, honoured with freeze on
    tag = "R4";
    dbg_halt = 1'b1; rd(8'h08, 4);
    wr(8'h00, 32'h3); rd(8'h08, 5);
    // R5: status reports the freeze
    tag = "R5";
    rd(8'h04, 3); dbg_halt = 1'b0; rd(8'h04, 2); rd(8'h08, 3);
    dbg_halt = 1'b1; wr(8'h00, 32'h2); rd(8'h04, 2);
    // R3: stopped counter holds
    tag = "R3";
    dbg_halt = 1'b0; rd(8'h08, 4); rd(8'h0C, 2);
    // R11: read-only and unlisted offsets
    tag = "R11";
    wr(8'h24, 32'hFFFF_FFFF); rd(8'h24, 2);
    wr(8'h04, 32'hFFFF_FFFF); rd(8'h04, 2);
    wr(8'h10, 32'h1234_5678); rd(8'h10, 2);
    wr(8'h01, 32'h0000_0003); rd(8'h00, 2); rd(8'h01, 2); rd(8'h20, 2);
    // Mixed traffic with random halt and writes
    tag = "R8";
    for (int i = 0; i < 400; i++) begin
      logic [7:0] offs [0:6];
      offs = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h20, 8'h24, 8'h18};
      dbg_halt = ($urandom_range(0, 3) == 0);
      addr = offs[$urandom_range(0, 6)];
      wdata = $urandom;
      if (addr == 8'h00) wdata[1:0] = 2'($urandom_range(0, 3));
      we = ($urandom_range(0, 5) == 0);
      @(negedge clk);
      we = 1'b0;
    end
    rd(8'h08, 2);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule